// File: doc/BRIEF.md
# Multichannel Audio Delay Resolver

This block turns the delay settings of an eight-channel audio delay line into one effective delay per channel. The eight channels are four serial lines, each with a left and a right channel. Each channel's delay is built from two parts. The first is a delay shared by a pair of lines, counted in steps of 16 samples. The second is a per-channel offset counted in single samples. The sum of the two is multiplied by a factor of 1, 2 or 4, chosen by a two-bit code, so that the same settings cover a higher sampling rate. The result is clamped to a 16-bit range.

Two tracking flags let a single register drive several channels, so software can give every channel the same delay with few writes. The block registers a snapshot of all settings on the word-boundary strobe. It publishes all eight results together on the following strobe, which is what the memory read-pointer logic downstream reads. Alongside the clamped set value, it reports the total delay, which adds the fixed two-sample pipeline latency. It also gives a one-cycle change pulse per channel, which a mute sequencer can use.

Top module: `audio_delay_resolver`

## Requirements
- R1: The shared delay counts in 16-sample units. Lines A and B (channels 0 to 3) take `com_dly_ab`, and lines C and D (channels 4 to 7) take `com_dly_cd`. With a shift code of 2'b00 and a zero individual delay, channel c's set value is 16 × its shared register.
- R2: `ind_dly[c*12 +: 12]` is channel c's individual delay in samples. Channels are numbered 0 to 7 in the order A-left, A-right, B-left, B-right, C-left, C-right, D-left, D-right.
- R3: `shift_code` selects the multiplier applied to (16 × shared + individual). The encoding is 2'b00 → ×1, 2'b01 → ×2, 2'b10 → ×4, 2'b11 → ×1.
- R4: A product of 65536 or more gives a set value of 65535. For example, shared 1023 with individual 16 at ×4 gives 65535, and shared 1023 with individual 15 at ×4 gives 65532.
- R5: Each channel's total delay equals its set value plus 2, so a channel programmed to zero reports a total of 2.
- R6: When `track_com` is 1, `com_dly_ab` feeds all eight channels and `com_dly_cd` has no effect.
- R7: When `track_ind` is 1, channel 0's individual field feeds channels 0 to 3 and channel 4's feeds channels 4 to 7. The fields of channels 1, 2, 3, 5, 6 and 7 have no effect.
- R8: Inputs are captured only on a clock edge where `word_strobe` is 1. Outputs change only on strobe edges. A setting captured at one strobe appears at the outputs after the next strobe.
- R9: A synchronous reset makes every set value 0, every total 2 and every change pulse 0.
- R10: On a strobe edge, `chg_pulse[c]` becomes 1 for one cycle exactly when channel c's new set value differs from its previous one. It is 0 after any edge without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_strobe | input | 1 | Word-boundary strobe, one cycle per word |
| com_dly_ab | input | 12 | Shared delay for lines A and B, 16-sample units |
| com_dly_cd | input | 12 | Shared delay for lines C and D, 16-sample units |
| ind_dly | input | 96 | Eight individual delays, 12 bits each, channel 0 in the low bits |
| track_com | input | 1 | Shared-delay tracking enable |
| track_ind | input | 1 | Individual-delay tracking enable |
| shift_code | input | 2 | Multiplier select |
| set_dly | output | 128 | Eight clamped set values, 16 bits each |
| total_dly | output | 136 | Eight total delays, 17 bits each |
| chg_pulse | output | 8 | Per-channel change pulse |

## Verification
The hardest situations to reach from the ports sit at the saturation boundary. A product landing exactly on 65535, or one sample beyond it, needs specific pairs of shared and individual values for each multiplier. The bench drives these pairs directly for ×1, ×2 and ×4 and mixes them with random settings, which are biased toward small shared values so that unsaturated results stay common.

The "no effect" cases under tracking are checked by loading conflicting values into the ignored registers and comparing every channel's output with the model. Each setting is followed through both strobes, so the bench observes the held old values between the strobes as well as the change pulses.

// File: rtl/adr_pkg.sv
package adr_pkg;

  typedef enum logic [1:0] {
    MUL_ONE_A = 2'b00,
    MUL_TWO   = 2'b01,
    MUL_FOUR  = 2'b10,
    MUL_ONE_B = 2'b11
  } shift_code_e;

  // Left-shift amount that realizes the selected multiplier.
  function automatic logic [1:0] shift_amount(input logic [1:0] code);
    case (shift_code_e'(code))
      MUL_TWO:  return 2'd1;
      MUL_FOUR: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/adr_capture.sv
module adr_capture #(
  parameter int NUM_CH = 8,
  parameter int COM_W  = 12,
  parameter int IND_W  = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              strobe,
  input  logic [COM_W-1:0]                  com_ab,
  input  logic [COM_W-1:0]                  com_cd,
  input  logic [NUM_CH-1:0][IND_W-1:0]      ind_in,
  input  logic                              trk_com,
  input  logic                              trk_ind,
  input  logic [1:0]                        shift_in,
  output logic [NUM_CH-1:0][COM_W-1:0]      com_sel,
  output logic [NUM_CH-1:0][IND_W-1:0]      ind_sel,
  output logic [1:0]                        shift_q
);
  localparam int HALF = NUM_CH / 2;

  logic [COM_W-1:0]             com_ab_q, com_cd_q;
  logic [NUM_CH-1:0][IND_W-1:0] ind_q;
  logic                         trk_com_q, trk_ind_q;

  // Snapshot of all settings on the word boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      com_ab_q  <= '0;
      com_cd_q  <= '0;
      ind_q     <= '0;
      trk_com_q <= 1'b0;
      trk_ind_q <= 1'b0;
      shift_q   <= '0;
    end else if (strobe) begin
      com_ab_q  <= com_ab;
      com_cd_q  <= com_cd;
      ind_q     <= ind_in;
      trk_com_q <= trk_com;
      trk_ind_q <= trk_ind;
      shift_q   <= shift_in;
    end
  end

  // Per-channel source selection under the tracking flags.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    localparam int LEAD = (c < HALF) ? 0 : HALF;
    if (c < HALF) begin : g_lo
      assign com_sel[c] = com_ab_q;
    end else begin : g_hi
      assign com_sel[c] = trk_com_q ? com_ab_q : com_cd_q;
    end
    assign ind_sel[c] = trk_ind_q ? ind_q[LEAD] : ind_q[c];
  end

  AST_TRACK_COM_ALL: assert property (@(posedge clk) disable iff (rst)
    trk_com_q |-> (com_sel[NUM_CH-1] == com_sel[0])); // R6

  AST_TRACK_IND_GROUP: assert property (@(posedge clk) disable iff (rst)
    trk_ind_q |-> ((ind_sel[HALF-1] == ind_sel[0]) &&
                   (ind_sel[NUM_CH-1] == ind_sel[HALF]))); // R7

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(shift_q)); // R8

endmodule

// File: rtl/adr_chan_calc.sv
module adr_chan_calc
  import adr_pkg::*;
#(
  parameter int COM_W     = 12,
  parameter int IND_W     = 12,
  parameter int COM_SHIFT = 4,
  parameter int SET_W     = 16
) (
  input  logic [COM_W-1:0] com,
  input  logic [IND_W-1:0] ind,
  input  logic [1:0]       shift,
  output logic [SET_W-1:0] set_val
);
  localparam int SCL_W  = COM_W + COM_SHIFT;
  localparam int SUM_W  = ((SCL_W > IND_W) ? SCL_W : IND_W) + 1;
  localparam int PROD_W = SUM_W + 2;

  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod;
  logic              ovf;

  always_comb begin
    sum     = SUM_W'({com, {COM_SHIFT{1'b0}}}) + SUM_W'(ind);
    prod    = {2'b00, sum} << shift_amount(shift);
    ovf     = |prod[PROD_W-1:SET_W];
    set_val = ovf ? {SET_W{1'b1}} : prod[SET_W-1:0];
  end

endmodule

// File: rtl/adr_outreg.sv
module adr_outreg #(
  parameter int NUM_CH   = 8,
  parameter int SET_W    = 16,
  parameter int TOT_W    = 17,
  parameter int PIPE_LAT = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         strobe,
  input  logic [NUM_CH-1:0][SET_W-1:0] next_set,
  output logic [NUM_CH-1:0][SET_W-1:0] set_q,
  output logic [NUM_CH-1:0][TOT_W-1:0] total_q,
  output logic [NUM_CH-1:0]            chg_q
);
  localparam logic [TOT_W-1:0] LAT = TOT_W'(PIPE_LAT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        set_q[c]   <= '0;
        total_q[c] <= LAT;
        chg_q[c]   <= 1'b0;
      end else if (strobe) begin
        set_q[c]   <= next_set[c];
        total_q[c] <= {{(TOT_W-SET_W){1'b0}}, next_set[c]} + LAT;
        chg_q[c]   <= (next_set[c] != set_q[c]);
      end else begin
        chg_q[c]   <= 1'b0;
      end
    end

    AST_PULSE_MEANS_DELTA: assert property (@(posedge clk) disable iff (rst)
      chg_q[c] |-> (set_q[c] != $past(set_q[c]))); // R10

    AST_TOTAL_FLOOR: assert property (@(posedge clk) disable iff (rst)
      total_q[c] >= LAT); // R5

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (set_q[c] == '0 && total_q[c] == LAT)); // R9
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(set_q)); // R8

  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (chg_q == '0)); // R10

endmodule

// File: rtl/audio_delay_resolver.sv
module audio_delay_resolver #(
  parameter int NUM_LINES = 4,
  parameter int COM_W     = 12,
  parameter int IND_W     = 12,
  parameter int COM_SHIFT = 4,
  parameter int SET_W     = 16,
  parameter int PIPE_LAT  = 2,
  localparam int NUM_CH   = 2 * NUM_LINES,
  localparam int TOT_W    = SET_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      word_strobe,
  input  logic [COM_W-1:0]          com_dly_ab,
  input  logic [COM_W-1:0]          com_dly_cd,
  input  logic [NUM_CH*IND_W-1:0]   ind_dly,
  input  logic                      track_com,
  input  logic                      track_ind,
  input  logic [1:0]                shift_code,
  output logic [NUM_CH*SET_W-1:0]   set_dly,
  output logic [NUM_CH*TOT_W-1:0]   total_dly,
  output logic [NUM_CH-1:0]         chg_pulse
);
  logic [NUM_CH-1:0][IND_W-1:0] ind_arr;
  logic [NUM_CH-1:0][COM_W-1:0] com_sel;
  logic [NUM_CH-1:0][IND_W-1:0] ind_sel;
  logic [1:0]                   shift_q;
  logic [NUM_CH-1:0][SET_W-1:0] next_set;
  logic [NUM_CH-1:0][SET_W-1:0] set_q;
  logic [NUM_CH-1:0][TOT_W-1:0] total_q;

  assign ind_arr = ind_dly;

  adr_capture #(
    .NUM_CH (NUM_CH),
    .COM_W  (COM_W),
    .IND_W  (IND_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .strobe   (word_strobe),
    .com_ab   (com_dly_ab),
    .com_cd   (com_dly_cd),
    .ind_in   (ind_arr),
    .trk_com  (track_com),
    .trk_ind  (track_ind),
    .shift_in (shift_code),
    .com_sel  (com_sel),
    .ind_sel  (ind_sel),
    .shift_q  (shift_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_calc
    adr_chan_calc #(
      .COM_W     (COM_W),
      .IND_W     (IND_W),
      .COM_SHIFT (COM_SHIFT),
      .SET_W     (SET_W)
    ) u_calc (
      .com     (com_sel[c]),
      .ind     (ind_sel[c]),
      .shift   (shift_q),
      .set_val (next_set[c])
    );
  end

  adr_outreg #(
    .NUM_CH   (NUM_CH),
    .SET_W    (SET_W),
    .TOT_W    (TOT_W),
    .PIPE_LAT (PIPE_LAT)
  ) u_outreg (
    .clk      (clk),
    .rst      (rst),
    .strobe   (word_strobe),
    .next_set (next_set),
    .set_q    (set_q),
    .total_q  (total_q),
    .chg_q    (chg_pulse)
  );

  assign set_dly   = set_q;
  assign total_dly = total_q;

endmodule

// File: tb/test_audio_delay_resolver.sv
module test_audio_delay_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_strobe = 1'b0;
  logic [11:0] com_dly_ab = '0;
  logic [11:0] com_dly_cd = '0;
  logic [95:0] ind_dly = '0;
  logic        track_com = 1'b0;
  logic        track_ind = 1'b0;
  logic [1:0]  shift_code = '0;
  logic [127:0] set_dly;
  logic [135:0] total_dly;
  logic [7:0]   chg_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cur_exp [8];

  always #10 clk = ~clk;

  audio_delay_resolver i_audio_delay_resolver (
    .clk(clk), .rst(rst), .word_strobe(word_strobe),
    .com_dly_ab(com_dly_ab), .com_dly_cd(com_dly_cd), .ind_dly(ind_dly),
    .track_com(track_com), .track_ind(track_ind), .shift_code(shift_code),
    .set_dly(set_dly), .total_dly(total_dly), .chg_pulse(chg_pulse)
  );

  function automatic int model(int c);
    int com, ind, src, s;
    com = (track_com || c < 4) ? int'(com_dly_ab) : int'(com_dly_cd);
    src = track_ind ? ((c < 4) ? 0 : 4) : c;
    ind = int'(ind_dly[src*12 +: 12]);
    s = com * 16 + ind;
    case (shift_code)
      2'b01:   s = s * 2;
      2'b10:   s = s * 4;
      default: s = s;
    endcase
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs are set at a negedge before the call; follows both strobes.
  task automatic apply(string tag);
    int nw [8];
    for (int c = 0; c < 8; c++) nw[c] = model(c);
    word_strobe = 1'b1;
    @(negedge clk);
    word_strobe = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 8; c++)
      check("R8", int'(set_dly[c*16 +: 16]), cur_exp[c], $sformatf("hold ch%0d", c));
    check("R10", int'(chg_pulse), 0, "pulse before second strobe");
    word_strobe = 1'b1;
    @(negedge clk);
    word_strobe = 1'b0;
    for (int c = 0; c < 8; c++) begin
      check(tag, int'(set_dly[c*16 +: 16]), nw[c], $sformatf("set ch%0d", c));
      check("R5", int'(total_dly[c*17 +: 17]), nw[c] + 2, $sformatf("total ch%0d", c));
      check("R10", int'(chg_pulse[c]), int'(nw[c] != cur_exp[c]), $sformatf("pulse ch%0d", c));
    end
    @(negedge clk);
    check("R10", int'(chg_pulse), 0, "pulse one cycle");
    for (int c = 0; c < 8; c++) cur_exp[c] = nw[c];
  endtask

  task automatic set_all_ind(int v);
    for (int c = 0; c < 8; c++) ind_dly[c*12 +: 12] = 12'(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      cur_exp[c] = 0;
      check("R9", int'(set_dly[c*16 +: 16]), 0, $sformatf("reset set ch%0d", c));
      check("R9", int'(total_dly[c*17 +: 17]), 2, $sformatf("reset total ch%0d", c));
    end
    check("R9", int'(chg_pulse), 0, "reset pulse");

    // R1: shared delay only, per group
    com_dly_ab = 12'd5; com_dly_cd = 12'd9;
    apply("R1");
    // R2: distinct individual values
    com_dly_ab = '0; com_dly_cd = '0;
    for (int c = 0; c < 8; c++) ind_dly[c*12 +: 12] = 12'(100 * c + 7);
    apply("R2");
    // R3: every shift code
    com_dly_ab = 12'd3; com_dly_cd = 12'd6;
    for (int k = 0; k < 4; k++) begin
      shift_code = 2'(k);
      apply("R3");
    end
    // R4: saturation boundary pairs
    set_all_ind(15); shift_code = 2'b00; com_dly_ab = 12'hFFF; apply("R4");
    set_all_ind(16); apply("R4");
    shift_code = 2'b01; com_dly_ab = 12'h7FF; set_all_ind(15); apply("R4");
    set_all_ind(16); apply("R4");
    shift_code = 2'b10; com_dly_ab = 12'h3FF; set_all_ind(15); apply("R4");
    set_all_ind(16); apply("R4");
    // R5: all zero gives total 2
    com_dly_ab = '0; com_dly_cd = '0; set_all_ind(0); shift_code = 2'b00;
    apply("R5");
    // R6: shared tracking ignores com_dly_cd
    for (int c = 0; c < 8; c++) ind_dly[c*12 +: 12] = 12'(c);
    track_com = 1'b1; com_dly_ab = 12'd40; com_dly_cd = 12'd700;
    apply("R6");
    com_dly_cd = 12'd1; apply("R6");
    track_com = 1'b0;
    // R7: individual tracking ignores non-lead fields
    track_ind = 1'b1;
    for (int c = 0; c < 8; c++) ind_dly[c*12 +: 12] = 12'(300 + 11 * c);
    apply("R7");
    ind_dly[12 +: 12] = 12'd4000; ind_dly[84 +: 12] = 12'd1; apply("R7");
    track_ind = 1'b0;
    // R8: unchanged settings leave outputs and pulses quiet
    apply("R8");

    void'($urandom(32'd4242));
    for (int it = 0; it < 40; it++) begin
      com_dly_ab = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 512);
      com_dly_cd = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 512);
      for (int c = 0; c < 8; c++) ind_dly[c*12 +: 12] = 12'($urandom);
      track_com  = ($urandom % 4 == 0);
      track_ind  = ($urandom % 4 == 0);
      shift_code = 2'($urandom);
      apply("R1/R2/R3/R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule